// File: doc/BRIEF.md
# Asynchronous handshake bus master

This block is the master side of a strobe-and-acknowledge system bus. It runs one 32-bit read or write cycle at a time. A local requester pulses `start_i` with a word address, a direction, write data and a channel tag. The engine then drives the address, a read/write line, an address strobe and a data strobe. It ends the cycle when the memory side returns a transfer acknowledge or a bus-error indication.

All timing is counted in half bus-clock steps on a clock that runs at twice the bus rate, so each `clk_i` period is half a bus clock. The address strobe falls one step after the cycle starts. The data strobe falls in the same step on a read, and two steps later on a write, where write data appears one step before it. The acknowledge and error inputs pass through a synchronizer. The engine samples them on the step that stands for the falling edge of the third bus clock, and after that on every second step. When either is seen, read data is captured, both strobes rise for one step and the cycle ends with a done pulse. A read that ends in a bus error also pulses an interrupt and an abort request for the tagged channel. On a write, the same error only sets the error flag.

Top module: `abm_master`

## Requirements
- R1: After reset, `as_n_o` and `ds_n_o` are high, and `busy_o`, `done_o`, `err_o`, `irq_o`, `abort_o` and `bus_d_oe_o` are low.
- R2: A start is accepted while idle. Counting the first cycle after acceptance as step 0, `as_n_o` is low from step 1 until the release step. Throughout the cycle, `bus_addr_o` equals the accepted address and `bus_rw_o` is 1 for a read and 0 for a write.
- R3: On a write, `bus_d_oe_o` is high with the write data on `bus_d_o` from step 2 through the release step, and `ds_n_o` is low from step 3 until the release step. When `bus_d_oe_o` is low, `bus_d_o` is zero.
- R4: On a read, `ds_n_o` falls at step 1 together with `as_n_o`, and the data bus is never driven.
- R5: Active-low `ack_n_i` is seen two clocks after it is applied, through a two-stage synchronizer. It is sampled at step 5 and at every odd step after it. When it is seen at step k, step k+1 is the release step, with both strobes high, and `done_o` pulses for one clock at step k+2.
- R6: On a read, `rdata_o` takes the value on `bus_d_i` at the terminating sample and holds it until the next read ends.
- R7: Active-low `berr_n_i` ends a cycle with the same timing as the acknowledge, whether it arrives alone or with it. `err_o` pulses together with `done_o` only when the error ended the cycle.
- R8: A read ended by a bus error pulses `irq_o` and `abort_o` with `done_o`, and `abort_chan_o` shows the channel tag of that cycle. A write ended by a bus error leaves `irq_o` and `abort_o` low.
- R9: `busy_o` is high from step 0 through the release step. A start that arrives while busy is ignored, and the address, direction and data of the running cycle stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate clock, one period per half bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request |
| we_i | input | 1 | Direction, 1 = write |
| addr_i | input | WA_W | Word address |
| wdata_i | input | DW | Write data |
| chan_i | input | CHW | Channel tag of the request |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock end-of-cycle pulse |
| err_o | output | 1 | Cycle ended by bus error (with done) |
| rdata_o | output | DW | Captured read data |
| irq_o | output | 1 | Read-error interrupt pulse |
| abort_o | output | 1 | Channel abort request pulse |
| abort_chan_o | output | CHW | Channel tag of the current or last cycle |
| bus_addr_o | output | WA_W | Bus word address |
| bus_rw_o | output | 1 | 1 = read, 0 = write |
| as_n_o | output | 1 | Address strobe, active low |
| ds_n_o | output | 1 | Data strobe, active low |
| bus_d_o | output | DW | Bus write data |
| bus_d_oe_o | output | 1 | Data bus drive enable |
| bus_d_i | input | DW | Bus read data |
| ack_n_i | input | 1 | Transfer acknowledge, active low |
| berr_n_i | input | 1 | Bus error, active low |

## Verification
The bench builds the block with its defaults: a 30-bit word address, 32-bit data, a 5-bit channel tag, two synchronizer stages, a first sample at step 5 and write strobe delays of two and three steps. These values give each direction a distinct strobe pattern. Acknowledge delays from zero to about a dozen clocks then cover the cycle with no wait and with several waits, including an acknowledge that lands on an off step and must wait for the next sample. With the error input driven alone and together with the acknowledge in both directions, the interrupt path can be told apart from the write-error path.

// File: rtl/abm_pkg.sv
package abm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_REL  = 2'd2
  } abm_state_e;
endpackage

// File: rtl/abm_sync.sv
module abm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= RST_VAL;
        else         sr_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/abm_phase.sv
module abm_phase #(
  parameter int SAMPLE_H = 5,
  parameter int PH_W     = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            run_i,
  output logic [PH_W-1:0] ph_o,
  output logic            sample_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(SAMPLE_H);

  logic [PH_W-1:0] ph_q;
  logic            odd_q;   // skip every other step once in the wait window

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      odd_q <= 1'b0;
    end else if (clear_i) begin
      ph_q  <= '0;
      odd_q <= 1'b0;
    end else if (run_i) begin
      if (ph_q < LAST) ph_q  <= ph_q + 1'b1;
      else             odd_q <= ~odd_q;
    end
  end

  assign ph_o     = ph_q;
  assign sample_o = run_i && (ph_q == LAST) && !odd_q;
endmodule

// File: rtl/abm_strobe.sv
module abm_strobe #(
  parameter int PH_W       = 3,
  parameter int AS_H       = 1,
  parameter int RD_DS_H    = 1,
  parameter int WR_DAT_H   = 2,
  parameter int WR_DS_H    = 3
) (
  input  logic            run_i,
  input  logic            rel_i,
  input  logic            we_i,
  input  logic [PH_W-1:0] ph_i,
  output logic            as_n_o,
  output logic            ds_n_o,
  output logic            oe_o
);
  localparam logic [PH_W-1:0] AS_T  = PH_W'(AS_H);
  localparam logic [PH_W-1:0] RDS_T = PH_W'(RD_DS_H);
  localparam logic [PH_W-1:0] WDT_T = PH_W'(WR_DAT_H);
  localparam logic [PH_W-1:0] WDS_T = PH_W'(WR_DS_H);

  logic [PH_W-1:0] ds_t;

  always_comb begin
    ds_t   = we_i ? WDS_T : RDS_T;
    as_n_o = !(run_i && (ph_i >= AS_T));
    ds_n_o = !(run_i && (ph_i >= ds_t));
    oe_o   = we_i && ((run_i && (ph_i >= WDT_T)) || rel_i);
  end
endmodule

// File: rtl/abm_master.sv
module abm_master
  import abm_pkg::*;
#(
  parameter int WA_W      = 30,
  parameter int DW        = 32,
  parameter int CHW       = 5,
  parameter int SYNC_N    = 2,
  parameter int AS_H      = 1,
  parameter int RD_DS_H   = 1,
  parameter int WR_DAT_H  = 2,
  parameter int WR_DS_H   = 3,
  parameter int SAMPLE_H  = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            we_i,
  input  logic [WA_W-1:0] addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [CHW-1:0]  chan_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_o,
  output logic            abort_o,
  output logic [CHW-1:0]  abort_chan_o,
  output logic [WA_W-1:0] bus_addr_o,
  output logic            bus_rw_o,
  output logic            as_n_o,
  output logic            ds_n_o,
  output logic [DW-1:0]   bus_d_o,
  output logic            bus_d_oe_o,
  input  logic [DW-1:0]   bus_d_i,
  input  logic            ack_n_i,
  input  logic            berr_n_i
);
  localparam int PH_W = $clog2(SAMPLE_H + 1);

  abm_state_e      st_q;
  logic            we_q, err_q;
  logic [WA_W-1:0] addr_q;
  logic [DW-1:0]   wdata_q;
  logic [CHW-1:0]  chan_q;
  logic [PH_W-1:0] ph;
  logic            sample, go, run, rel, oe;
  logic            ack_sn, berr_sn, ack_s, berr_s;

  assign go  = (st_q == ST_IDLE) && start_i;
  assign run = (st_q == ST_RUN);
  assign rel = (st_q == ST_REL);

  abm_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync_ack (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_n_i), .q_o(ack_sn)
  );
  abm_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync_err (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(berr_n_i), .q_o(berr_sn)
  );
  assign ack_s  = !ack_sn;
  assign berr_s = !berr_sn;

  abm_phase #(.SAMPLE_H(SAMPLE_H), .PH_W(PH_W)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(go), .run_i(run),
    .ph_o(ph), .sample_o(sample)
  );

  abm_strobe #(
    .PH_W(PH_W), .AS_H(AS_H), .RD_DS_H(RD_DS_H),
    .WR_DAT_H(WR_DAT_H), .WR_DS_H(WR_DS_H)
  ) u_strobe (
    .run_i(run), .rel_i(rel), .we_i(we_q), .ph_i(ph),
    .as_n_o(as_n_o), .ds_n_o(ds_n_o), .oe_o(oe)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      we_q    <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      chan_q  <= '0;
      rdata_o <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      irq_o   <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      irq_o   <= 1'b0;
      abort_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q    <= ST_RUN;
          we_q    <= we_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          chan_q  <= chan_i;
        end
        ST_RUN: if (sample && (ack_s || berr_s)) begin
          st_q  <= ST_REL;
          err_q <= berr_s;
          if (!we_q) rdata_o <= bus_d_i;
        end
        ST_REL: begin
          st_q    <= ST_IDLE;
          done_o  <= 1'b1;
          err_o   <= err_q;
          irq_o   <= err_q && !we_q;   // write errors raise no interrupt
          abort_o <= err_q && !we_q;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign bus_addr_o   = addr_q;
  assign bus_rw_o     = !we_q;
  assign bus_d_oe_o   = oe;
  assign bus_d_o      = oe ? wdata_q : '0;
  assign abort_chan_o = chan_q;
endmodule

// File: rtl/abm_chk.sv
module abm_chk #(
  parameter int WA_W = 30
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_o,
  input logic            done_o,
  input logic            err_o,
  input logic            irq_o,
  input logic            abort_o,
  input logic            as_n_o,
  input logic            ds_n_o,
  input logic            bus_rw_o,
  input logic            bus_d_oe_o,
  input logic [WA_W-1:0] bus_addr_o
);
  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_n_o && !$past(as_n_o)) |-> $stable(bus_addr_o));

  // R3
  ds_inside_as_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ds_n_o |-> !as_n_o);

  // R4
  no_drive_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_d_oe_o |-> !bus_rw_o);

  // R5
  release_then_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(as_n_o) |=> done_o);

  // R7
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  // R8
  irq_on_read_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (err_o && bus_rw_o && abort_o));

  // R9
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));
endmodule

bind abm_master abm_chk #(.WA_W(WA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .err_o(err_o), .irq_o(irq_o), .abort_o(abort_o), .as_n_o(as_n_o),
  .ds_n_o(ds_n_o), .bus_rw_o(bus_rw_o), .bus_d_oe_o(bus_d_oe_o),
  .bus_addr_o(bus_addr_o)
);

// File: tb/tb_abm_master.sv
`timescale 1ns/1ps
module tb_abm_master;
  localparam int WA_W = 30;
  localparam int DW   = 32;
  localparam int CHW  = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0, we = 1'b0;
  logic [WA_W-1:0] addr = '0;
  logic [DW-1:0]   wdata = '0, bus_din = '0;
  logic [CHW-1:0]  ch = '0;
  logic            ack_n = 1'b1, berr_n = 1'b1;

  logic            busy, done, err, irq, abrt, rw, as_n, ds_n, oe;
  logic [DW-1:0]   rdata, bus_dout;
  logic [CHW-1:0]  abrt_ch;
  logic [WA_W-1:0] baddr;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #2 clk = ~clk;   // 250 MHz

  abm_master dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .chan_i(ch), .busy_o(busy), .done_o(done), .err_o(err),
    .rdata_o(rdata), .irq_o(irq), .abort_o(abrt), .abort_chan_o(abrt_ch),
    .bus_addr_o(baddr), .bus_rw_o(rw), .as_n_o(as_n), .ds_n_o(ds_n),
    .bus_d_o(bus_dout), .bus_d_oe_o(oe), .bus_d_i(bus_din),
    .ack_n_i(ack_n), .berr_n_i(berr_n)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference model: mode 0 idle, 1 running, 2 release; t counts half steps
  int              mode, t;
  bit              s1a, s2a, s1e, s2e;
  bit              mwe, merr, e_done, e_err, e_irq, e_abort;
  logic [WA_W-1:0] maddr;
  logic [DW-1:0]   mwd, mrd;
  logic [CHW-1:0]  mch;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode = 0; t = 0; s1a = 0; s2a = 0; s1e = 0; s2e = 0;
      mwe = 0; merr = 0; maddr = '0; mwd = '0; mrd = '0; mch = '0;
      e_done = 0; e_err = 0; e_irq = 0; e_abort = 0;
    end else begin
      bit av, ev;
      av = s2a; ev = s2e;
      s2a = s1a; s1a = !ack_n;
      s2e = s1e; s1e = !berr_n;
      e_done = 0; e_err = 0; e_irq = 0; e_abort = 0;
      if (mode == 0) begin
        if (start) begin
          mode = 1; t = 0; mwe = we; maddr = addr; mwd = wdata; mch = ch;
        end
      end else if (mode == 1) begin
        if (t >= 5 && ((t - 5) % 2) == 0 && (av || ev)) begin
          mode = 2; merr = ev;
          if (!mwe) mrd = bus_din;
        end
        t = t + 1;
      end else begin
        mode = 0; e_done = 1; e_err = merr;
        e_irq = merr && !mwe; e_abort = e_irq;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit run, rel, x_oe;
      run  = (mode == 1);
      rel  = (mode == 2);
      x_oe = mwe && ((run && t >= 2) || rel);
      chk("R2 as_n", as_n, !(run && t >= 1));
      chk(mwe ? "R3 ds_n write" : "R4 ds_n read", ds_n, !(run && t >= (mwe ? 3 : 1)));
      chk("R3 data oe", oe, x_oe);
      chk("R3 data out", bus_dout, x_oe ? mwd : '0);
      chk("R2 address", baddr, maddr);
      chk("R2 direction", rw, !mwe);
      chk("R9 busy", busy, mode != 0);
      chk("R5 done", done, e_done);
      chk("R7 err", err, e_err);
      chk("R8 irq", irq, e_irq);
      chk("R8 abort", abrt, e_abort);
      chk("R8 abort chan", abrt_ch, mch);
      chk("R6 rdata", rdata, mrd);
    end
  end

  always @(negedge clk) bus_din <= $urandom;

  task automatic run_cycle(input bit w, input logic [WA_W-1:0] a, input logic [DW-1:0] d,
                           input logic [CHW-1:0] c, input int wait_n,
                           input bit use_ack, input bit use_err, input bit poke);
    int guard;
    @(negedge clk);
    start = 1; we = w; addr = a; wdata = d; ch = c;
    @(negedge clk);
    start = 0; we = !w; addr = ~a; wdata = ~d; ch = ~c;
    if (poke) begin   // R9: start while busy must be ignored
      start = 1;
      @(negedge clk);
      start = 0;
    end
    repeat (wait_n) @(negedge clk);
    ack_n = !use_ack; berr_n = !use_err;
    guard = 0;
    while (!done && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    ack_n = 1; berr_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 as_n", as_n, 1'b1);
    chk("R1 ds_n", ds_n, 1'b1);
    chk("R1 busy", busy, 1'b0);
    chk("R1 done", done, 1'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 oe", oe, 1'b0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_cycle(0, 30'h0000_1234, 32'h0, 5'd1, 0, 1, 0, 0);          // R4 R5 R6 no wait
    run_cycle(1, 30'h0ABC_0000, 32'hDEAD_BEEF, 5'd2, 0, 1, 0, 0);  // R3 no wait
    run_cycle(0, 30'h1000_0001, 32'h0, 5'd3, 9, 1, 0, 0);          // R5 waits
    run_cycle(1, 30'h2000_0002, 32'h1234_5678, 5'd4, 6, 1, 0, 0);  // R5 odd landing
    run_cycle(0, 30'h0000_0F00, 32'h0, 5'd17, 2, 0, 1, 0);         // R8 read error
    run_cycle(1, 30'h0000_0E00, 32'hCAFE_F00D, 5'd9, 2, 0, 1, 0);  // R8 write error
    run_cycle(0, 30'h3FFF_FFFF, 32'h0, 5'd31, 4, 1, 1, 0);         // R7 both
    run_cycle(1, 30'h0000_00AA, 32'h5555_AAAA, 5'd5, 3, 1, 1, 0);  // R7 both on write
    run_cycle(0, 30'h0123_4567, 32'h0, 5'd6, 5, 1, 0, 1);          // R9 poke
    run_cycle(1, 30'h0765_4321, 32'h0F0F_0F0F, 5'd7, 1, 1, 0, 1);  // R9 poke
    for (int i = 0; i < 24; i++)
      run_cycle(bit'($urandom_range(0, 1)), WA_W'($urandom), $urandom,
                CHW'($urandom), $urandom_range(0, 12),
                bit'(i % 3 != 0), bit'(i % 3 != 1), bit'(i % 5 == 0));
    repeat (4) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule